// File: doc/BRIEF.md
# Programmable Interval Timer Peripheral

A register-mapped peripheral holding one or two independent 32-bit interval timers behind a simple word-access bus. Each timer has a control word, a load word and a live counter word. Software writes a load value, then writes the control word with the enable bit set. The counter starts from the load value and moves one step per clock, either down toward zero or up toward all-ones. When it reaches that terminal value, the timer raises a status flag. It then reloads and keeps running, or stops and holds the terminal value.

The status flags of all timers, each gated by its own interrupt-enable bit, are ORed onto one registered, level-sensitive interrupt line. A control write with the status bit set clears the flag. Read data is registered: it appears one clock after the address is presented. A build-time parameter reduces the block to a single timer.

Top module: `interval_timer`

## Requirements
- R1: After reset every register reads zero, no timer runs and `irq` is low.
- R2: A control write keeps bits 10:0 of the data, except bit 8. Bits 31:11 of the control word always read zero. Bit 8 reads the timer's status flag.
- R3: A control write with bit 7 set copies the load word into the counter and starts counting. A control write with bit 7 clear stops the timer, and the counter then holds its value.
- R4: With control bit 1 set, the running counter decrements once per clock. On the clock after it holds zero, the timer expires.
- R5: With control bit 1 clear, the running counter increments once per clock. On the clock after it holds 0xFFFFFFFF, the timer expires.
- R6: Expiry sets the status flag. If control bit 4 is clear, the timer stops and the counter holds its terminal value.
- R7: If control bit 4 is set, expiry copies the load word into the counter and counting continues. Counting down from load L, the period is L+1 clocks.
- R8: A control write with bit 8 set clears the status flag. A control write with bit 8 clear leaves the flag unchanged. No write can set the flag.
- R9: `irq` is high exactly one clock after some timer has both its flag and its control bit 6 (interrupt enable) set.
- R10: The byte address bits 3:2 select the word within a timer: 0 control, 1 load, 2 counter, 3 reserved. The higher address bits select the timer, and each timer occupies 16 bytes. The reserved word reads zero. Writes to the counter word and to the reserved word are ignored.
- R11: With `SINGLE` set, only timer 0 exists. The window of timer 1 reads zero, and writes to it are ignored.
- R12: `rdata` presents, one clock after `addr`, the value the addressed register held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the word accessed |
| we | input | 1 | Write strobe for a full 32-bit word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Shared, level-sensitive interrupt |

## Verification
The bench builds two copies on a shared bus. One copy uses the default two-timer build and the other sets `SINGLE`. Both therefore see the same writes to both timer windows. This makes the missing second timer of the reduced build observable on its read data and interrupt line while the full build exercises it. Random loads, directions and interrupt-enable choices run through the expiry boundary. Directed cases cover stop, restart, auto-reload, flag clear rules and the word map.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int CTL_W  = 11;
  localparam int B_DOWN = 1;
  localparam int B_ARL  = 4;
  localparam int B_IE   = 6;
  localparam int B_EN   = 7;
  localparam int B_FLAG = 8;

  typedef enum logic [1:0] {
    W_CTRL = 2'd0,
    W_LOAD = 2'd1,
    W_CNT  = 2'd2,
    W_RSVD = 2'd3
  } word_e;
endpackage

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_load,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] cnt_o,
  output logic          req_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             flag_q, run_q;
  logic [DW-1:0]    load_q, cnt_q;
  logic             down, at_end, hit;

  assign down   = ctl_q[B_DOWN];
  assign at_end = down ? (cnt_q == '0) : (&cnt_q);
  assign hit    = run_q & ~wr_ctrl & at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      flag_q <= 1'b0;
      run_q  <= 1'b0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) begin
        ctl_q <= wdata[CTL_W-1:0] & ~(CTL_W'(1) << B_FLAG);
        run_q <= wdata[B_EN];
        if (wdata[B_EN]) cnt_q <= load_q;
      end else if (run_q) begin
        if (at_end) begin
          if (ctl_q[B_ARL]) cnt_q <= load_q;
          else              run_q <= 1'b0;
        end else if (down) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (wr_ctrl && wdata[B_FLAG]) flag_q <= 1'b0;
      else if (hit)                 flag_q <= 1'b1;
    end
  end

  assign ctrl_o = {{(DW-CTL_W){1'b0}}, ctl_q | (CTL_W'(flag_q) << B_FLAG)};
  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign req_o  = flag_q & ctl_q[B_IE];

  assert_down_step_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && down && !wr_ctrl && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_up_step_R5: assert property (@(posedge clk) disable iff (rst)
    (run_q && !down && !wr_ctrl && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_flag_from_run_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(run_q));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_ctrl) |=> $stable(cnt_q));
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wdata[B_FLAG]) |=> !flag_q);
endmodule

// File: rtl/ivt_collect.sv
module ivt_collect
  import ivt_pkg::*;
#(
  parameter int NT   = 2,
  parameter int DW   = 32,
  parameter int SELW = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] tsel,
  input  logic [1:0]      word,
  input  logic [NT*DW-1:0] ctrl_all,
  input  logic [NT*DW-1:0] load_all,
  input  logic [NT*DW-1:0] cnt_all,
  input  logic [NT-1:0]   req,
  output logic [DW-1:0]   rdata,
  output logic            irq
);
  logic [DW-1:0] rd_n;

  always_comb begin
    rd_n = '0;
    for (int i = 0; i < NT; i++) begin
      if (32'(tsel) == i) begin
        case (word_e'(word))
          W_CTRL:  rd_n = ctrl_all[i*DW +: DW];
          W_LOAD:  rd_n = load_all[i*DW +: DW];
          W_CNT:   rd_n = cnt_all[i*DW +: DW];
          default: rd_n = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      rdata <= rd_n;
      irq   <= |req;
    end
  end

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|req));
  assert_irq_lag_R9: assert property (@(posedge clk) disable iff (rst)
    (|req) |=> irq);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import ivt_pkg::*;
#(
  parameter bit SINGLE = 1'b0,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int DW   = 32;
  localparam int NT   = SINGLE ? 1 : 2;
  localparam int SELW = ADDR_W - 4;

  logic [SELW-1:0]   tsel;
  logic [1:0]        word;
  logic [NT*DW-1:0]  ctrl_all, load_all, cnt_all;
  logic [NT-1:0]     req;

  assign tsel = addr[ADDR_W-1:4];
  assign word = addr[3:2];

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    logic hit_me;
    assign hit_me = we && (32'(tsel) == g);
    ivt_channel #(.DW(DW)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .wr_ctrl(hit_me && word == W_CTRL),
      .wr_load(hit_me && word == W_LOAD),
      .wdata  (wdata),
      .ctrl_o (ctrl_all[g*DW +: DW]),
      .load_o (load_all[g*DW +: DW]),
      .cnt_o  (cnt_all[g*DW +: DW]),
      .req_o  (req[g])
    );
  end

  ivt_collect #(.NT(NT), .DW(DW), .SELW(SELW)) u_col (
    .clk     (clk),
    .rst     (rst),
    .tsel    (tsel),
    .word    (word),
    .ctrl_all(ctrl_all),
    .load_all(load_all),
    .cnt_all (cnt_all),
    .req     (req),
    .rdata   (rdata),
    .irq     (irq)
  );

  assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_all[31:11] == '0));
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata1;
  logic        irq, irq1;
  logic [31:0] rv, rv1;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  interval_timer #(.SINGLE(1'b0), .ADDR_W(5)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata), .irq(irq));
  interval_timer #(.SINGLE(1'b1), .ADDR_W(5)) u_dut1 (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata1), .irq(irq1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    addr = a;
    @(negedge clk);
    rv = rdata; rv1 = rdata1;
  endtask

  function automatic logic [31:0] ctl_word(bit dn, bit ie);
    return 32'h80 | (dn ? 32'h2 : 32'h0) | (ie ? 32'h40 : 32'h0);
  endfunction

  // Expiry after n steps from load; down: load n, up: load ~n.
  task automatic run_expiry(input int t, input bit dn, input bit ie, input int n);
    logic [4:0]  b = 5'(t * 16);
    logic [31:0] c = ctl_word(dn, ie);
    wr(b + 5'h4, dn ? 32'(n) : ~32'(n));
    wr(b, c);
    repeat (n) @(negedge clk);
    rd(b);
    chk("R4/R5 flag still low at terminal", rv, c);
    chk("R9 irq low before expiry", 32'(irq), 32'h0);
    rd(b);
    chk("R6 flag set after expiry", rv, c | 32'h100);
    chk("R9 irq follows flag and enable", 32'(irq), 32'(ie));
    chk("R11 single build irq", 32'(irq1), (t == 0) ? 32'(ie) : 32'h0);
    rd(b + 5'h8);
    chk("R6 counter holds terminal", rv, dn ? 32'h0 : 32'hFFFF_FFFF);
    wr(b, 32'h100);
    @(negedge clk);
    chk("R8/R9 irq drops after clear", 32'(irq), 32'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    rd(5'h00); chk("R1 ctrl0 reset", rv, 32'h0);
    rd(5'h08); chk("R1 cnt0 reset", rv, 32'h0);
    rd(5'h14); chk("R1 load1 reset", rv, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);

    wr(5'h00, 32'hFFFF_FE7F);
    rd(5'h00); chk("R2 ctrl keeps low bits", rv, 32'h0000_067F);
    wr(5'h00, 32'h0);
    wr(5'h00, 32'h100);
    rd(5'h00); chk("R8 write cannot set flag", rv, 32'h0);

    wr(5'h04, 32'h1234);
    rd(5'h04); chk("R10 load word", rv, 32'h1234);
    wr(5'h08, 32'hDEAD);
    rd(5'h08); chk("R10 counter write ignored", rv, 32'h0);
    wr(5'h0C, 32'h5);
    rd(5'h0C); chk("R10 reserved reads zero", rv, 32'h0);
    wr(5'h14, 32'hABCD);
    rd(5'h14); chk("R10 timer1 load", rv, 32'hABCD);
    chk("R11 single build window1 zero", rv1, 32'h0);
    rd(5'h04); chk("R10 timer0 load kept", rv, 32'h1234);
    chk("R11 single build timer0", rv1, 32'h1234);

    // R3 stop and hold, then restart
    wr(5'h04, 32'd100);
    wr(5'h00, 32'h82);
    repeat (5) @(negedge clk);
    wr(5'h00, 32'h02);
    rd(5'h08); chk("R3 stop holds count", rv, 32'd95);
    repeat (3) @(negedge clk);
    rd(5'h08); chk("R3 still held", rv, 32'd95);
    wr(5'h00, 32'h82);
    rd(5'h08); chk("R3/R12 restart from load", rv, 32'd100);
    rd(5'h08); chk("R4 one step down", rv, 32'd99);
    wr(5'h00, 32'h100);

    // R7 auto-reload on timer 1
    wr(5'h14, 32'd3);
    wr(5'h10, 32'h92);
    repeat (3) @(negedge clk);
    rd(5'h18); chk("R7 reaches zero", rv, 32'h0);
    rd(5'h18); chk("R7 reloaded", rv, 32'd3);
    rd(5'h10); chk("R7 flag set", rv, 32'h192);
    rd(5'h18); chk("R7 keeps counting", rv, 32'd1);
    chk("R9 irq masked", 32'(irq), 32'h0);
    wr(5'h10, 32'h100);

    // R8 write without bit 8 keeps flag
    wr(5'h04, 32'd4);
    wr(5'h00, 32'hC2);
    repeat (6) @(negedge clk);
    wr(5'h00, 32'h42);
    rd(5'h00); chk("R8 flag kept", rv, 32'h142);
    chk("R9 irq high", 32'(irq), 32'h1);
    wr(5'h00, 32'h100);
    chk("R9 irq lags clear", 32'(irq), 32'h1);
    @(negedge clk);
    chk("R9 irq low", 32'(irq), 32'h0);

    run_expiry(0, 1'b1, 1'b1, 0);
    run_expiry(1, 1'b0, 1'b1, 2);
    run_expiry(0, 1'b0, 1'b0, 0);
    for (int k = 0; k < 24; k++) begin
      run_expiry(int'($urandom % 2), 1'($urandom), 1'($urandom), int'($urandom % 30));
    end

    done = 1'b1;
    finish_run();
  end
endmodule